// File: doc/BRIEF.md
# Jump Target Address Generator

This block works out where a control transfer goes and what return address it leaves behind, for a 32-bit core whose instructions can be as short as two bytes. Each cycle in which `valid_i` is high it decodes one instruction word. For the PC-relative jump the target is the PC plus a 21-bit signed offset whose lowest bit is implied. For the register-indirect jump the target is the register operand plus an unscaled 12-bit signed offset, with bit 0 of the sum cleared. For the add-upper-immediate-to-PC operation the result is the PC plus a 20-bit immediate placed in the upper bits.

Both jump kinds also return a link address taken from the PC before any update. When compressed instructions are turned off, a target that is not 4-byte aligned raises a misalignment flag. All results are registered and appear one clock edge after the strobe. An upper-immediate result followed by an indirect jump on that result reaches any address within 32 bits of the PC.

Top module: `jump_target_gen`

## Requirements
- R1: While `rst_n` is low and after it rises, until the first strobe, `target_o`, `link_o` and `upc_o` are 0 and `taken_o` and `misalign_o` are 0.
- R2: For opcode bits[6:0]=1101111, `target_o` = PC + sext(off). Here off is 21 bits: off[20]=instr[31], off[19:12]=instr[19:12], off[11]=instr[20], off[10:1]=instr[30:21], off[0]=0. The reach covers -1 MiB to +1 MiB-2, and `taken_o` is 1.
- R3: For opcode 1100111 with bits[14:12]=000, `target_o` = (rs1 + sext(instr[31:20])) with bit 0 forced to 0. The offset is not multiplied by two, and `taken_o` is 1.
- R4: An indirect jump with a zero immediate gives `target_o` equal to rs1 with bit 0 cleared.
- R5: For opcode 0010111, `upc_o` = PC + {instr[31:12], 12'b0}. In that case `taken_o`, `target_o` and `link_o` are 0.
- R6: For both jump kinds, `link_o` = PC + 4, computed from the strobed PC and independent of rs1.
- R7: Results appear at the first rising edge after the strobe. In a cycle with `valid_i` low, the next edge clears `taken_o` and `misalign_o` and holds `target_o`, `link_o` and `upc_o`.
- R8: `misalign_o` is 1 exactly when the result is taken, bit 1 of the target is 1, and `rvc_en_i` was 0 at the strobe.
- R9: Any other opcode, or opcode 1100111 with bits[14:12] not 000, gives `taken_o`, `target_o`, `link_o` and `upc_o` all 0.
- R10: An upper-immediate result U followed by an indirect jump with rs1=U and immediate L reaches PC + (hi<<12) + sext(L) for an arbitrary 32-bit offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs1_i | input | 32 | Base register operand |
| rvc_en_i | input | 1 | High when 2-byte instructions are enabled |
| target_o | output | 32 | Registered jump target |
| link_o | output | 32 | Registered return address |
| upc_o | output | 32 | Registered upper-immediate-plus-PC result |
| taken_o | output | 1 | Registered jump indication |
| misalign_o | output | 1 | Registered target-misalignment flag |

## Verification
The assertions check on every cycle:
- a taken target always has bit 0 clear;
- the flags clear and the values hold when there is no strobe;
- the misalignment flag only appears with a taken target whose bit 1 is set;
- the link address follows the strobed PC;
- non-jump encodings never report a jump.

Only the bench scenarios can show that the scattered offset fields are reassembled in the correct order. The same goes for the exact ends of the ±1 MiB reach, the absence of offset scaling in the indirect jump, and the two-instruction far-jump composition.

// File: rtl/jtg_pkg.sv
package jtg_pkg;

  typedef enum logic [1:0] {
    JK_NONE  = 2'd0,
    JK_PCREL = 2'd1,
    JK_INDIR = 2'd2,
    JK_UPPC  = 2'd3
  } jkind_e;

  localparam logic [6:0] OPC_PCREL = 7'b1101111;
  localparam logic [6:0] OPC_INDIR = 7'b1100111;
  localparam logic [6:0] OPC_UPPC  = 7'b0010111;
  localparam logic [2:0] F3_INDIR  = 3'b000;

  // Argument is instruction bits 31:12; up[k] corresponds to instr[k+12].
  function automatic logic [20:0] pcrel_off(input logic [19:0] up);
    return {up[19], up[7:0], up[8], up[18:9], 1'b0};
  endfunction

  function automatic logic [11:0] indir_off(input logic [19:0] up);
    return up[19:8];
  endfunction

  function automatic logic [19:0] upper_imm(input logic [19:0] up);
    return up;
  endfunction

endpackage

// File: rtl/jtg_decode.sv
module jtg_decode
  import jtg_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  output jkind_e     kind_o
);
  always_comb begin
    kind_o = JK_NONE;
    if (opcode_i == OPC_PCREL)
      kind_o = JK_PCREL;
    else if (opcode_i == OPC_INDIR && funct3_i == F3_INDIR)
      kind_o = JK_INDIR;
    else if (opcode_i == OPC_UPPC)
      kind_o = JK_UPPC;
  end
endmodule

// File: rtl/jtg_imm_gen.sv
module jtg_imm_gen
  import jtg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [19:0]     upper_i,
  output logic [XLEN-1:0] imm_pcrel_o,
  output logic [XLEN-1:0] imm_indir_o,
  output logic [XLEN-1:0] imm_uppc_o
);
  localparam int PCREL_W = 21;
  localparam int INDIR_W = 12;

  logic [PCREL_W-1:0] raw_j;
  logic [INDIR_W-1:0] raw_i;
  logic [31:0]        raw_u;

  assign raw_j = pcrel_off(upper_i);
  assign raw_i = indir_off(upper_i);
  assign raw_u = {upper_imm(upper_i), 12'b0};

  assign imm_pcrel_o = {{(XLEN-PCREL_W){raw_j[PCREL_W-1]}}, raw_j};
  assign imm_indir_o = {{(XLEN-INDIR_W){raw_i[INDIR_W-1]}}, raw_i};

  generate
    if (XLEN > 32) begin : g_wide
      assign imm_uppc_o = {{(XLEN-32){raw_u[31]}}, raw_u};
    end else begin : g_narrow
      assign imm_uppc_o = raw_u[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/jtg_calc.sv
module jtg_calc
  import jtg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int LINK_STEP = 4
) (
  input  jkind_e          kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_pcrel_i,
  input  logic [XLEN-1:0] imm_indir_i,
  input  logic [XLEN-1:0] imm_uppc_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o,
  output logic [XLEN-1:0] upc_o,
  output logic            taken_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(LINK_STEP);

  logic [XLEN-1:0] pcrel_sum;
  logic [XLEN-1:0] indir_sum;
  logic [XLEN-1:0] uppc_sum;
  logic [XLEN-1:0] link_sum;

  assign pcrel_sum = pc_i + imm_pcrel_i;
  assign indir_sum = rs1_i + imm_indir_i;
  assign uppc_sum  = pc_i + imm_uppc_i;
  assign link_sum  = pc_i + STEP;

  always_comb begin
    target_o = '0;
    link_o   = '0;
    upc_o    = '0;
    taken_o  = 1'b0;
    unique case (kind_i)
      JK_PCREL: begin
        target_o = pcrel_sum;
        link_o   = link_sum;
        taken_o  = 1'b1;
      end
      JK_INDIR: begin
        target_o = {indir_sum[XLEN-1:1], 1'b0};
        link_o   = link_sum;
        taken_o  = 1'b1;
      end
      JK_UPPC:  upc_o = uppc_sum;
      default:  ;
    endcase
  end
endmodule

// File: rtl/jump_target_gen.sv
module jump_target_gen
  import jtg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int LINK_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic            rvc_en_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o,
  output logic [XLEN-1:0] upc_o,
  output logic            taken_o,
  output logic            misalign_o
);
  jkind_e          dec_kind;
  logic            dec_is_jump;
  logic [XLEN-1:0] imm_j, imm_i, imm_u;
  logic [XLEN-1:0] nxt_target, nxt_link, nxt_upc;
  logic            nxt_taken, nxt_misalign;

  jtg_decode u_dec (
    .opcode_i (instr_i[6:0]),
    .funct3_i (instr_i[14:12]),
    .kind_o   (dec_kind)
  );

  assign dec_is_jump = (dec_kind == JK_PCREL) || (dec_kind == JK_INDIR);

  jtg_imm_gen #(.XLEN(XLEN)) u_imm (
    .upper_i     (instr_i[31:12]),
    .imm_pcrel_o (imm_j),
    .imm_indir_o (imm_i),
    .imm_uppc_o  (imm_u)
  );

  jtg_calc #(.XLEN(XLEN), .LINK_STEP(LINK_STEP)) u_calc (
    .kind_i      (dec_kind),
    .pc_i        (pc_i),
    .rs1_i       (rs1_i),
    .imm_pcrel_i (imm_j),
    .imm_indir_i (imm_i),
    .imm_uppc_i  (imm_u),
    .target_o    (nxt_target),
    .link_o      (nxt_link),
    .upc_o       (nxt_upc),
    .taken_o     (nxt_taken)
  );

  assign nxt_misalign = nxt_taken && nxt_target[1] && !rvc_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_o   <= '0;
      link_o     <= '0;
      upc_o      <= '0;
      taken_o    <= 1'b0;
      misalign_o <= 1'b0;
    end else if (valid_i) begin
      target_o   <= nxt_target;
      link_o     <= nxt_link;
      upc_o      <= nxt_upc;
      taken_o    <= nxt_taken;
      misalign_o <= nxt_misalign;
    end else begin
      taken_o    <= 1'b0;
      misalign_o <= 1'b0;
    end
  end
endmodule

// File: rtl/jtg_sva.sv
module jtg_sva #(
  parameter int XLEN      = 32,
  parameter int LINK_STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [XLEN-1:0] pc_i,
  input logic            rvc_en_i,
  input logic            dec_is_jump,
  input logic [XLEN-1:0] target_o,
  input logic [XLEN-1:0] link_o,
  input logic [XLEN-1:0] upc_o,
  input logic            taken_o,
  input logic            misalign_o
);
  a_r2_even_target: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> !target_o[0]);

  a_r7_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!taken_o && !misalign_o));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(target_o) && $stable(link_o) && $stable(upc_o)));

  a_r8_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (taken_o && target_o[1]));

  a_r8_rvc_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && rvc_en_i) |=> !misalign_o);

  a_r6_link: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dec_is_jump) |=> (link_o == $past(pc_i) + XLEN'(LINK_STEP)));

  a_r9_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !dec_is_jump) |=> (!taken_o && target_o == '0));
endmodule

bind jump_target_gen jtg_sva #(.XLEN(XLEN), .LINK_STEP(LINK_STEP)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .pc_i        (pc_i),
  .rvc_en_i    (rvc_en_i),
  .dec_is_jump (dec_is_jump),
  .target_o    (target_o),
  .link_o      (link_o),
  .upc_o       (upc_o),
  .taken_o     (taken_o),
  .misalign_o  (misalign_o)
);

// File: tb/sim_jump_target_gen.sv
`timescale 1ns/1ps
module sim_jump_target_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] rs1_i = '0;
  logic        rvc_en_i = 1'b1;
  logic [31:0] target_o, link_o, upc_o;
  logic        taken_o, misalign_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  jump_target_gen u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .rs1_i(rs1_i), .rvc_en_i(rvc_en_i),
    .target_o(target_o), .link_o(link_o), .upc_o(upc_o),
    .taken_o(taken_o), .misalign_o(misalign_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_pcrel(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_indir(input logic [11:0] imm, input logic [2:0] f3);
    return {imm, 5'd6, f3, 5'd1, 7'b1100111};
  endfunction
  function automatic logic [31:0] enc_uppc(input logic [19:0] hi);
    return {hi, 5'd5, 7'b0010111};
  endfunction

  // Present one instruction; results are sampled at the next falling edge.
  task automatic issue(input logic [31:0] ins, input logic [31:0] pc, input logic [31:0] rs1);
    @(negedge clk);
    instr_i = ins; pc_i = pc; rs1_i = rs1; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 target", target_o, 0); chk("R1 link", link_o, 0);
    chk("R1 upc", upc_o, 0); chk("R1 taken", {31'b0, taken_o}, 0);
    chk("R1 misalign", {31'b0, misalign_o}, 0);
  endtask

  task automatic t_pcrel(input logic [31:0] pc, input logic [20:0] off);
    logic [31:0] exp_t;
    exp_t = pc + {{11{off[20]}}, off};
    issue(enc_pcrel(off), pc, 32'hDEAD_BEEF);
    chk("R2 pcrel target", target_o, exp_t);
    chk("R2 pcrel taken", {31'b0, taken_o}, 1);
    chk("R6 pcrel link", link_o, pc + 4);
  endtask

  task automatic t_indir_small;
    issue(enc_indir(12'd5, 3'b000), 32'h100, 32'h3000);
    chk("R3 unscaled target", target_o, 32'h3004);
    chk("R3 taken", {31'b0, taken_o}, 1);
    chk("R6 indir link", link_o, 32'h104);
  endtask

  task automatic t_indir_neg_misalign;
    rvc_en_i = 1'b0;
    issue(enc_indir(12'hFFF, 3'b000), 32'h200, 32'h4000);
    chk("R3 negative target", target_o, 32'h3FFE);
    chk("R8 misalign set", {31'b0, misalign_o}, 1);
    rvc_en_i = 1'b1;
    issue(enc_indir(12'hFFF, 3'b000), 32'h200, 32'h4000);
    chk("R8 masked by rvc", {31'b0, misalign_o}, 0);
    rvc_en_i = 1'b0;
    issue(enc_indir(12'h004, 3'b000), 32'h200, 32'h4000);
    chk("R8 aligned clear", {31'b0, misalign_o}, 0);
    rvc_en_i = 1'b1;
  endtask

  task automatic t_indir_zero;
    issue(enc_indir(12'd0, 3'b000), 32'h0, 32'h0000_8001);
    chk("R4 zero imm target", target_o, 32'h0000_8000);
  endtask

  task automatic t_uppc;
    issue(enc_uppc(20'h12345), 32'h100, 32'h55);
    chk("R5 upc", upc_o, 32'h1234_5100);
    chk("R5 not taken", {31'b0, taken_o}, 0);
    chk("R5 target zero", target_o, 0);
    chk("R5 link zero", link_o, 0);
  endtask

  task automatic t_other;
    issue(enc_indir(12'd8, 3'b010), 32'h300, 32'h3000);
    chk("R9 bad funct3 taken", {31'b0, taken_o}, 0);
    chk("R9 bad funct3 target", target_o, 0);
    issue({12'd8, 5'd6, 3'b000, 5'd1, 7'b0010011}, 32'h300, 32'h3000);
    chk("R9 other op taken", {31'b0, taken_o}, 0);
    chk("R9 other op link", link_o, 0);
    chk("R9 other op upc", upc_o, 0);
  endtask

  task automatic t_hold;
    issue(enc_pcrel(21'h40), 32'h1000, 32'h0);
    @(negedge clk);
    chk("R7 taken cleared", {31'b0, taken_o}, 0);
    chk("R7 target held", target_o, 32'h1040);
    chk("R7 link held", link_o, 32'h1004);
  endtask

  task automatic t_far_pair;
    logic [31:0] pc, u;
    pc = 32'h1000_0000;
    issue(enc_uppc(20'h00ABD), pc, 32'h0);
    u = upc_o;
    chk("R10 upper part", u, pc + 32'h00AB_D000);
    issue(enc_indir(12'h800, 3'b000), pc + 4, u);
    chk("R10 far target", target_o, pc + 32'h00AB_C800);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pcrel(32'h0000_1000, 21'h000020);
    t_pcrel(32'h0020_0000, 21'h0FFFFE);
    t_pcrel(32'h0020_0000, 21'h100000);
    t_pcrel(32'h0000_8000, 21'h1FFFF0);
    t_indir_small();
    t_indir_neg_misalign();
    t_indir_zero();
    t_uppc();
    t_other();
    t_hold();
    t_far_pair();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule